// File: doc/BRIEF.md
# End-of-String Byte Detector

This block watches the bytes that pass through an instrument-bus talker/listener and compares each one against a programmable terminator byte. Software loads the terminator through a one-byte write port. A mode bit selects whether the compare covers all eight bits or only the low seven bits, so the terminator can be an ASCII character or a binary pattern.

The block acts on a match in one of two ways, depending on the direction of the byte. When a received byte matches and end-on-receive is enabled, a sticky END status bit is set. That bit drives the interrupt output when its enable is set, and it stays set until the host reads the status. When an outgoing byte matches and EOI-on-send is enabled, the block raises EOI together with that byte. EOI stays high until the byte's handshake completes.

The two match paths are independent. When a mode bit is clear, matches in its direction have no effect. The handshakes themselves and the wider interrupt controller sit outside this block.

Top module: `eos_match_unit`

## Requirements
- R1: After synchronous reset, `end_stat`, `irq` and `eoi_out` are 0 and the terminator register holds 0x00.
- R2: A terminator write takes effect at the clock edge that samples it. A strobe in the same cycle as the write is compared against the old value.
- R3: With `mode_seven` = 0, a byte matches only if all eight bits equal the terminator.
- R4: With `mode_seven` = 1, only bits 6..0 are compared. Bit 7 of both the byte and the terminator is ignored.
- R5: A `rx_strobe` whose byte matches, sampled while `mode_end_rx` = 1, makes `end_stat` read 1 from the next cycle.
- R6: `end_stat` stays 1 until a cycle with `stat_rd` = 1 clears it. If a set and a read happen in the same cycle, the set wins.
- R7: `irq` is registered. It is 1 in a cycle exactly when `end_stat` is 1 in that cycle and `end_ie` was 1 at the preceding edge.
- R8: A `tx_strobe` whose byte matches, sampled while `mode_eoi_tx` = 1, makes `eoi_out` read 1 from the next cycle.
- R9: `eoi_out` holds until a cycle with `tx_done` = 1 and then drops. If `tx_strobe` occurs in the same cycle, the new byte decides `eoi_out`.
- R10: When a mode bit is clear, matches in its direction have no effect. A non-matching byte never sets `end_stat`, and it loads `eoi_out` with 0.
- R11: A transmitted byte never affects `end_stat`, and a received byte never affects `eoi_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eos_wr_en | input | 1 | Load terminator register |
| eos_wr_data | input | DATA_W | Terminator value to load |
| mode_seven | input | 1 | 1 = compare low seven bits only |
| mode_end_rx | input | 1 | Enable END status on received match |
| mode_eoi_tx | input | 1 | Enable EOI on transmitted match |
| rx_strobe | input | 1 | Received byte valid |
| rx_byte | input | DATA_W | Received byte |
| tx_strobe | input | 1 | Outgoing byte loaded |
| tx_byte | input | DATA_W | Outgoing byte |
| tx_done | input | 1 | Handshake of outgoing byte complete |
| end_ie | input | 1 | Interrupt enable for END |
| stat_rd | input | 1 | Host status read; clears END |
| end_stat | output | 1 | Sticky END status bit |
| irq | output | 1 | Gated interrupt request |
| eoi_out | output | 1 | EOI to accompany current outgoing byte |

## Verification
The bench sweeps all 256 byte values in both directions, in both compare widths, against terminators whose top bit is set and clear. A comparator that kept bit 7 in narrow mode, or dropped it in wide mode, would report wrong matches there. Directed cases cover a terminator write in the same cycle as a strobe, where a design that forwards the new value would match too early. They also cover a status read in the same cycle as a new match, where a clear-first design would lose an event. Further cases cover `tx_done` together with a new outgoing byte, interrupt gating, and cross-direction isolation. A design that leaked matches between directions, or dropped EOI before the handshake, would fail these.

// File: rtl/eos_pkg.sv
package eos_pkg;
  typedef struct packed {
    logic narrow;
    logic end_on_rx;
    logic eoi_on_tx;
  } eos_mode_t;
endpackage

// File: rtl/eos_cmp.sv
module eos_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ref_byte,
  input  logic [DATA_W-1:0] cand,
  input  logic              narrow,
  output logic              match
);
  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] lane_ok;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i == TOP) begin : g_top
        assign lane_ok[i] = narrow | (ref_byte[i] ~^ cand[i]);
      end else begin : g_low
        assign lane_ok[i] = ref_byte[i] ~^ cand[i];
      end
    end
  endgenerate

  assign match = &lane_ok;
endmodule

// File: rtl/eos_end_flag.sv
module eos_end_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag;
    if (clr_req) flag_nxt = 1'b0;
    if (set_req) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt & ie;
    end
  end

  // R6: sticky while no read
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    flag && !clr_req |=> flag);
  // R6: set wins over clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_req |=> flag);
  // R7: interrupt never without status
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  // R7: enable low blocks interrupt
  a_r7_ie_low: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

// File: rtl/eos_eoi_ctl.sv
module eos_eoi_ctl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic done,
  output logic eoi
);
  always_ff @(posedge clk) begin
    if (rst)       eoi <= 1'b0;
    else if (load) eoi <= load_val;
    else if (done) eoi <= 1'b0;
  end

  // R9: held until handshake completes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    eoi && !done && !load |=> eoi);
  // R9: dropped on handshake completion
  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    done && !load |=> !eoi);
endmodule

// File: rtl/eos_match_unit.sv
module eos_match_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eos_wr_en,
  input  logic [DATA_W-1:0] eos_wr_data,
  input  logic              mode_seven,
  input  logic              mode_end_rx,
  input  logic              mode_eoi_tx,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_strobe,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              end_ie,
  input  logic              stat_rd,
  output logic              end_stat,
  output logic              irq,
  output logic              eoi_out
);
  import eos_pkg::*;

  eos_mode_t         mode;
  logic [DATA_W-1:0] eos_q;
  logic              rx_match;
  logic              tx_match;

  assign mode = '{narrow: mode_seven, end_on_rx: mode_end_rx, eoi_on_tx: mode_eoi_tx};

  always_ff @(posedge clk) begin
    if (rst)            eos_q <= '0;
    else if (eos_wr_en) eos_q <= eos_wr_data;
  end

  eos_cmp #(.DATA_W(DATA_W)) u_cmp_rx (
    .ref_byte (eos_q),
    .cand     (rx_byte),
    .narrow   (mode.narrow),
    .match    (rx_match)
  );

  eos_cmp #(.DATA_W(DATA_W)) u_cmp_tx (
    .ref_byte (eos_q),
    .cand     (tx_byte),
    .narrow   (mode.narrow),
    .match    (tx_match)
  );

  eos_end_flag u_end (
    .clk     (clk),
    .rst     (rst),
    .set_req (rx_strobe & rx_match & mode.end_on_rx),
    .clr_req (stat_rd),
    .ie      (end_ie),
    .flag    (end_stat),
    .irq     (irq)
  );

  eos_eoi_ctl u_eoi (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_strobe),
    .load_val (tx_match & mode.eoi_on_tx),
    .done     (tx_done),
    .eoi      (eoi_out)
  );

  // R5: received match sets END
  a_r5_end_set: assert property (@(posedge clk) disable iff (rst)
    rx_strobe && rx_match && mode_end_rx |=> end_stat);
  // R8: transmitted match raises EOI
  a_r8_eoi_set: assert property (@(posedge clk) disable iff (rst)
    tx_strobe && tx_match && mode_eoi_tx |=> eoi_out);
  // R10: end-on-receive disabled keeps END clear
  a_r10_end_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode_end_rx && !end_stat |=> !end_stat);
  // R10: EOI-on-send disabled gives no EOI for a new byte
  a_r10_eoi_quiet: assert property (@(posedge clk) disable iff (rst)
    tx_strobe && !mode_eoi_tx |=> !eoi_out);
  // R11: received byte alone never raises EOI
  a_r11_rx_no_eoi: assert property (@(posedge clk) disable iff (rst)
    !eoi_out && !tx_strobe |=> !eoi_out);
endmodule

// File: tb/eos_match_unit_tb.sv
module eos_match_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       eos_wr_en;
  logic [7:0] eos_wr_data;
  logic       mode_seven, mode_end_rx, mode_eoi_tx;
  logic       rx_strobe;
  logic [7:0] rx_byte;
  logic       tx_strobe;
  logic [7:0] tx_byte;
  logic       tx_done, end_ie, stat_rd;
  logic       end_stat, irq, eoi_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eos_match_unit #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .eos_wr_en(eos_wr_en), .eos_wr_data(eos_wr_data),
    .mode_seven(mode_seven), .mode_end_rx(mode_end_rx), .mode_eoi_tx(mode_eoi_tx),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
    .tx_done(tx_done), .end_ie(end_ie), .stat_rd(stat_rd),
    .end_stat(end_stat), .irq(irq), .eoi_out(eoi_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_match(input logic [7:0] e, input logic [7:0] b, input bit seven);
    return seven ? (e[6:0] == b[6:0]) : (e == b);
  endfunction

  task automatic write_eos(input logic [7:0] v);
    @(negedge clk); eos_wr_en = 1; eos_wr_data = v;
    @(negedge clk); eos_wr_en = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_strobe = 1; rx_byte = b;
    @(negedge clk); rx_strobe = 0;
  endtask

  task automatic tx_send(input logic [7:0] b);
    @(negedge clk); tx_strobe = 1; tx_byte = b;
    @(negedge clk); tx_strobe = 0;
  endtask

  task automatic status_read();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic handshake_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] eos_list [4];
    eos_list[0] = 8'h0A; eos_list[1] = 8'h8D; eos_list[2] = 8'h00; eos_list[3] = 8'hFF;
    rst = 1; eos_wr_en = 0; eos_wr_data = 0; mode_seven = 0; mode_end_rx = 0;
    mode_eoi_tx = 0; rx_strobe = 0; rx_byte = 0; tx_strobe = 0; tx_byte = 0;
    tx_done = 0; end_ie = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 end_stat", {7'd0, end_stat}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 eoi_out", {7'd0, eoi_out}, 8'd0);
    mode_end_rx = 1;
    rx_send(8'h00);
    chk("R1 eos reset value 00", {7'd0, end_stat}, 8'd1);
    status_read();
    chk("R6 read clears", {7'd0, end_stat}, 8'd0);

    // R2: write and strobe in same cycle use old value
    @(negedge clk); eos_wr_en = 1; eos_wr_data = 8'h41; rx_strobe = 1; rx_byte = 8'h41;
    @(negedge clk); eos_wr_en = 0; rx_strobe = 0;
    chk("R2 same-cycle write uses old", {7'd0, end_stat}, 8'd0);
    rx_send(8'h41);
    chk("R2 new value after write", {7'd0, end_stat}, 8'd1);
    status_read();

    // Sweeps: R3, R4, R5, R7, R8, R9
    end_ie = 1; mode_end_rx = 1; mode_eoi_tx = 1;
    for (int e = 0; e < 4; e++) begin
      write_eos(eos_list[e]);
      for (int m = 0; m < 2; m++) begin
        mode_seven = m[0];
        for (int b = 0; b < 256; b++) begin
          bit x;
          x = exp_match(eos_list[e], b[7:0], m[0]);
          rx_send(b[7:0]);
          chk(m[0] ? "R4 R5 rx match" : "R3 R5 rx match", {7'd0, end_stat}, {7'd0, x});
          chk("R7 irq follows status", {7'd0, irq}, {7'd0, x});
          chk("R11 rx leaves eoi", {7'd0, eoi_out}, 8'd0);
          if (x) status_read();
          tx_send(b[7:0]);
          chk(m[0] ? "R4 R8 tx match" : "R3 R8 tx match", {7'd0, eoi_out}, {7'd0, x});
          chk("R11 tx leaves end_stat", {7'd0, end_stat}, 8'd0);
          if (x) begin
            @(negedge clk);
            chk("R9 eoi held", {7'd0, eoi_out}, 8'd1);
            handshake_done();
            chk("R9 eoi dropped", {7'd0, eoi_out}, 8'd0);
          end
        end
      end
    end

    // R6: set wins over same-cycle read
    mode_seven = 0;
    write_eos(8'h0D);
    rx_send(8'h0D);
    @(negedge clk); rx_strobe = 1; rx_byte = 8'h0D; stat_rd = 1;
    @(negedge clk); rx_strobe = 0; stat_rd = 0;
    chk("R6 set wins over read", {7'd0, end_stat}, 8'd1);
    rx_send(8'h33);
    chk("R6 sticky over non-match", {7'd0, end_stat}, 8'd1);
    status_read();
    chk("R6 cleared", {7'd0, end_stat}, 8'd0);

    // R7: interrupt gating
    end_ie = 0;
    rx_send(8'h0D);
    chk("R7 irq blocked", {7'd0, irq}, 8'd0);
    chk("R7 status still set", {7'd0, end_stat}, 8'd1);
    @(negedge clk); end_ie = 1;
    @(negedge clk);
    chk("R7 irq after enable", {7'd0, irq}, 8'd1);
    status_read();
    chk("R7 irq cleared", {7'd0, irq}, 8'd0);

    // R9: new byte in the same cycle as done
    tx_send(8'h0D);
    @(negedge clk); tx_strobe = 1; tx_byte = 8'h0D; tx_done = 1;
    @(negedge clk); tx_strobe = 0; tx_done = 0;
    chk("R9 new match beats done", {7'd0, eoi_out}, 8'd1);
    @(negedge clk); tx_strobe = 1; tx_byte = 8'h20; tx_done = 1;
    @(negedge clk); tx_strobe = 0; tx_done = 0;
    chk("R9 new non-match clears", {7'd0, eoi_out}, 8'd0);
    tx_send(8'h0D);
    tx_send(8'h20);
    chk("R10 non-match loads zero", {7'd0, eoi_out}, 8'd0);

    // R10: modes disabled
    mode_end_rx = 0; mode_eoi_tx = 0;
    rx_send(8'h0D);
    chk("R10 end disabled", {7'd0, end_stat}, 8'd0);
    chk("R10 irq disabled", {7'd0, irq}, 8'd0);
    tx_send(8'h0D);
    chk("R10 eoi disabled", {7'd0, eoi_out}, 8'd0);

    // R1: reset clears state
    mode_end_rx = 1; mode_eoi_tx = 1;
    rx_send(8'h0D);
    tx_send(8'h0D);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 end_stat after reset", {7'd0, end_stat}, 8'd0);
    chk("R1 eoi after reset", {7'd0, eoi_out}, 8'd0);
    rx_send(8'h00);
    chk("R1 eos cleared by reset", {7'd0, end_stat}, 8'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule